// File: doc/BRIEF.md
# Oversampled Phase Detector with Pattern-Trained Sample Selection

This block sits behind a front end that captures one serial bit period as a word of OSR samples taken at evenly spaced phases. Sample 0 is the earliest phase and sample OSR-1 the latest. One word arrives on every clock. The block finds where the data transition falls inside the bit period. It compares the ideal sampling point, which lies half a bit period after that transition, with the sample index currently in use. The signed phase error feeds an up/down accumulator. When the accumulator reaches a threshold, the block issues a single-cycle request to step an external variable phase shifter up or down. The recovered data bit is the selected sample of each word, delivered one clock later.

The initial sample index is picked by training. While `train_en` is high, the bits recovered at one candidate index are collected eight at a time, most significant bit first, and compared with a reference word. A failed comparison moves to the next candidate index. A run of LOCK_WORDS consecutive matches declares lock.

A three-state controller sequences the block:
- IDLE: after reset.
- HUNT: training. The START transition enters HUNT from IDLE when `train_en` is high. The ABORT transition returns to IDLE when `train_en` falls.
- TRACK: loop filter active. The ACQUIRE transition enters TRACK from HUNT on the final matching word. TRACK is left only by reset.

Top module: `ovs_phase_tracker`

## Requirements
- R1: After reset, `rec_bit`, `phase_up`, `phase_dn` and `locked` are 0, `sample_sel` is 0, and the controller is in IDLE.
- R2: Transitions are detected between each pair of adjacent samples. Sample 0 is also compared with the last sample of the previous word. When several transitions occur in one word, the edge position is the lowest sample index i at which sample i differs from its predecessor.
- R3: The target index is (edge + OSR/2) mod OSR. The phase error is (target - `sample_sel`) mod OSR, mapped to the signed range -OSR/2 .. OSR/2-1, and is added to the accumulator.
- R4: When accumulator plus error reaches +THRESH (8) or more, `phase_up` pulses for one cycle and the accumulator clears. When it reaches -THRESH or less, `phase_dn` pulses and the accumulator clears. The pulse is visible in the cycle after the word that caused it.
- R5: A word with no transition leaves the accumulator unchanged.
- R6: `phase_up` and `phase_dn` are never high in the same cycle.
- R7: Outside TRACK the accumulator is held at zero and no step pulse is issued, whatever the words contain.
- R8: In HUNT, bit `sample_sel` of each word is shifted in, first bit at the MSB. Every eighth bit the collected byte is compared with `ref_pat`. On a mismatch, `sample_sel` advances by one (mod OSR) and the match count clears.
- R9: `locked` rises after LOCK_WORDS (16) consecutive matching bytes. It then stays high, with `sample_sel` frozen, until reset.
- R10: `rec_bit` equals sample `sample_sel` of the word presented in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one sample word per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_word | input | OSR | Oversampled word, bit i is sample phase i |
| train_en | input | 1 | Level request to run pattern training |
| ref_pat | input | PAT_W | Reference byte for training, MSB sent first |
| rec_bit | output | 1 | Recovered data bit |
| phase_up | output | 1 | One-cycle request to advance the phase shifter |
| phase_dn | output | 1 | One-cycle request to retard the phase shifter |
| locked | output | 1 | Training succeeded, tracking active |
| sample_sel | output | log2(OSR) | Sample index in use |

## Verification
The bench builds the block with its defaults: OSR 8, THRESH 8, an 8-bit reference and a 16-byte lock run. With these values the whole error range from -4 to +3 is reachable. The bench chooses edge positions so that a pulse needs two, three or four words, which makes an off-by-one in the target offset or in the error wrap visible. Training with edges at sample 3 forces exactly three rejected candidates before index 3 is accepted, so the sweep, the match count and lock timing are all checked against one known bit count. Glitch words with two transitions show whether the lowest-index edge wins, because picking the later edge flips the sign of the error.

// File: rtl/ovs_pd_pkg.sv
package ovs_pd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HUNT  = 2'd1,
        ST_TRACK = 2'd2
    } trk_state_e;
endpackage

// File: rtl/ovs_edge_finder.sv
module ovs_edge_finder #(
    parameter int OSR   = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OSR-1:0]   word,
    output logic             edge_valid,
    output logic [IDX_W-1:0] edge_idx
);
    logic           prev_last;
    logic [OSR-1:0] trans;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_last <= 1'b0;
        else        prev_last <= word[OSR-1];
    end

    // boundary with previous word
    assign trans[0] = prev_last ^ word[0];
    for (genvar i = 1; i < OSR; i++) begin : g_trans
        assign trans[i] = word[i] ^ word[i-1];
    end

    // lowest index wins
    always_comb begin
        edge_idx = '0;
        for (int i = OSR - 1; i >= 0; i--) begin
            if (trans[i]) edge_idx = IDX_W'(i);
        end
    end

    assign edge_valid = |trans;

    // R2: a word reported edge-free must be flat and continue the previous level
    assert_flat_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_valid |-> (word == {OSR{prev_last}}));
endmodule

// File: rtl/ovs_loop_filter.sv
module ovs_loop_filter #(
    parameter int OSR    = 8,
    parameter int IDX_W  = 3,
    parameter int THRESH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             edge_valid,
    input  logic [IDX_W-1:0] edge_idx,
    input  logic [IDX_W-1:0] sel,
    output logic             step_up,
    output logic             step_dn
);
    localparam int ACC_W = $clog2(THRESH + OSR) + 1;
    localparam logic [IDX_W-1:0]        HALF = IDX_W'(OSR / 2);
    localparam logic signed [ACC_W-1:0] SPAN = ACC_W'(OSR);
    localparam logic signed [ACC_W-1:0] TH_P = ACC_W'(THRESH);
    localparam logic signed [ACC_W-1:0] TH_N = -TH_P;

    logic [IDX_W-1:0]        target;
    logic [IDX_W-1:0]        diff;
    logic signed [ACC_W-1:0] err;
    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] acc;

    assign target = edge_idx + HALF;
    assign diff   = target - sel;

    always_comb begin
        if (diff >= HALF) err = $signed(ACC_W'(diff)) - SPAN;
        else              err = $signed(ACC_W'(diff));
        sum = acc + err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc     <= '0;
            step_up <= 1'b0;
            step_dn <= 1'b0;
        end else begin
            step_up <= 1'b0;
            step_dn <= 1'b0;
            if (!en) begin
                acc <= '0;
            end else if (edge_valid) begin
                if (sum >= TH_P) begin
                    step_up <= 1'b1;
                    acc     <= '0;
                end else if (sum <= TH_N) begin
                    step_dn <= 1'b1;
                    acc     <= '0;
                end else begin
                    acc <= sum;
                end
            end
        end
    end

    assert_pulse_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn));

    assert_acc_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc < TH_P) && (acc > TH_N));

    assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !edge_valid) |=> (acc == $past(acc)));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!step_up && !step_dn));
endmodule

// File: rtl/ovs_train_fsm.sv
module ovs_train_fsm
    import ovs_pd_pkg::*;
#(
    parameter int OSR        = 8,
    parameter int IDX_W      = 3,
    parameter int PAT_W      = 8,
    parameter int LOCK_WORDS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             train_en,
    input  logic [OSR-1:0]   word,
    input  logic [PAT_W-1:0] ref_pat,
    output logic [IDX_W-1:0] sel,
    output logic             locked,
    output logic             track_en
);
    localparam int BIT_W = $clog2(PAT_W);
    localparam int CNT_W = $clog2(LOCK_WORDS);

    trk_state_e       state, nstate;
    logic [BIT_W-1:0] bit_cnt;
    logic [PAT_W-1:0] hist;
    logic [CNT_W-1:0] match_cnt;
    logic [PAT_W-1:0] hist_next;
    logic             word_done, word_ok, word_bad, acquire;

    assign hist_next = {hist[PAT_W-2:0], word[sel]};
    assign word_done = (bit_cnt == BIT_W'(PAT_W - 1));
    assign word_ok   = word_done && (hist_next == ref_pat);
    assign word_bad  = word_done && (hist_next != ref_pat);
    assign acquire   = word_ok && (match_cnt == CNT_W'(LOCK_WORDS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // transitions: START, ABORT, ACQUIRE
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (train_en) nstate = ST_HUNT;
            ST_HUNT: begin
                if (!train_en)    nstate = ST_IDLE;
                else if (acquire) nstate = ST_TRACK;
            end
            ST_TRACK: nstate = ST_TRACK;
            default:  nstate = ST_IDLE;
        endcase
    end

    // training datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel       <= '0;
            bit_cnt   <= '0;
            hist      <= '0;
            match_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    sel       <= '0;
                    bit_cnt   <= '0;
                    hist      <= '0;
                    match_cnt <= '0;
                end
                ST_HUNT: begin
                    if (train_en) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        hist    <= hist_next;
                        if (word_bad) begin
                            sel       <= sel + 1'b1;
                            match_cnt <= '0;
                        end else if (word_ok) begin
                            match_cnt <= match_cnt + 1'b1;
                        end
                    end
                end
                ST_TRACK: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        locked   = 1'b0;
        track_en = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_HUNT:  ;
            ST_TRACK: begin
                locked   = 1'b1;
                track_en = 1'b1;
            end
            default:  ;
        endcase
    end

    assert_cand_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && train_en && word_bad) |=> (sel == IDX_W'($past(sel) + 1'b1)));

    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    assert_sel_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(sel));

    assert_lock_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(match_cnt) == CNT_W'(LOCK_WORDS - 1)));
endmodule

// File: rtl/ovs_phase_tracker.sv
module ovs_phase_tracker #(
    parameter int OSR        = 8,
    parameter int THRESH     = 8,
    parameter int PAT_W      = 8,
    parameter int LOCK_WORDS = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [OSR-1:0]          samp_word,
    input  logic                    train_en,
    input  logic [PAT_W-1:0]        ref_pat,
    output logic                    rec_bit,
    output logic                    phase_up,
    output logic                    phase_dn,
    output logic                    locked,
    output logic [$clog2(OSR)-1:0]  sample_sel
);
    localparam int IDX_W = $clog2(OSR);

    logic             edge_valid;
    logic [IDX_W-1:0] edge_idx;
    logic             track_en;

    ovs_edge_finder #(.OSR(OSR), .IDX_W(IDX_W)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .word       (samp_word),
        .edge_valid (edge_valid),
        .edge_idx   (edge_idx)
    );

    ovs_train_fsm #(.OSR(OSR), .IDX_W(IDX_W), .PAT_W(PAT_W), .LOCK_WORDS(LOCK_WORDS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .train_en (train_en),
        .word     (samp_word),
        .ref_pat  (ref_pat),
        .sel      (sample_sel),
        .locked   (locked),
        .track_en (track_en)
    );

    ovs_loop_filter #(.OSR(OSR), .IDX_W(IDX_W), .THRESH(THRESH)) u_filt (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (track_en),
        .edge_valid (edge_valid),
        .edge_idx   (edge_idx),
        .sel        (sample_sel),
        .step_up    (phase_up),
        .step_dn    (phase_dn)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_bit <= 1'b0;
        else        rec_bit <= samp_word[sample_sel];
    end

    // R10: recovered bit follows the selected sample one cycle later
    assert_rec_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (rec_bit == $past(samp_word[sample_sel])));
endmodule

// File: tb/tb_ovs_phase_tracker.sv
module tb_ovs_phase_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] samp_word = 8'h00;
    logic       train_en = 1'b0;
    logic [7:0] ref_pat = 8'hB2;
    logic       rec_bit, phase_up, phase_dn, locked;
    logic [2:0] sample_sel;
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ovs_phase_tracker dut (
        .clk(clk), .rst_n(rst_n), .samp_word(samp_word), .train_en(train_en),
        .ref_pat(ref_pat), .rec_bit(rec_bit), .phase_up(phase_up),
        .phase_dn(phase_dn), .locked(locked), .sample_sel(sample_sel)
    );

    // tracking vectors {word, up, dn}; sample_sel is 3 after training
    localparam int NV = 21;
    localparam logic [9:0] TV [NV] = '{
        {8'h80, 1'b0, 1'b0},  // R3 edge 7 -> error 0
        {8'h7F, 1'b0, 1'b0},  // R3 error 0
        {8'hFE, 1'b0, 1'b0},  // edge 1 -> +2, acc 2
        {8'h01, 1'b0, 1'b0},  // acc 4
        {8'hFE, 1'b0, 1'b0},  // acc 6
        {8'h01, 1'b1, 1'b0},  // R4 reaches +8 -> up
        {8'hF8, 1'b0, 1'b0},  // R3 edge 3 -> -4 (wrap)
        {8'h07, 1'b0, 1'b1},  // R4 reaches -8 -> dn
        {8'hFC, 1'b0, 1'b0},  // edge 2 -> +3, acc 3
        {8'h03, 1'b0, 1'b0},  // acc 6
        {8'h00, 1'b0, 1'b0},  // R5 flat word, acc stays 6
        {8'h00, 1'b0, 1'b0},  // R5
        {8'h00, 1'b0, 1'b0},  // R5
        {8'hFF, 1'b0, 1'b0},  // R2 boundary edge 0 -> +1, acc 7
        {8'h00, 1'b1, 1'b0},  // R2 boundary edge 0, acc 8 -> up
        {8'h1E, 1'b0, 1'b0},  // R2 edges 1 and 5, lowest -> +2
        {8'h1E, 1'b0, 1'b0},  // acc 4
        {8'h1E, 1'b0, 1'b0},  // acc 6
        {8'h1E, 1'b1, 1'b0},  // R2 up (later edge would give dn)
        {8'hC0, 1'b0, 1'b0},  // R3 edge 6 -> -1
        {8'h0F, 1'b0, 1'b0}   // R3 edge 4 -> -3, acc -4
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] w);
        samp_word = w;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic lvl;
        logic b;
        logic [7:0] w;
        int pulses;
        int both;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 rec_bit", rec_bit, 0);
        chk("R1 phase_up", phase_up, 0);
        chk("R1 phase_dn", phase_dn, 0);
        chk("R1 locked", locked, 0);
        chk("R1 sample_sel", sample_sel, 0);
        rst_n = 1'b1;

        // R7 idle: words that would steer the loop produce no pulses
        pulses = 0;
        for (int i = 0; i < 8; i++) begin
            push((i % 2 == 0) ? 8'hFE : 8'h01);
            pulses += phase_up + phase_dn;
        end
        chk("R7 idle pulses", pulses, 0);
        chk("R7 idle locked", locked, 0);

        // training: START, then 19 bytes of pattern with edges at sample 3
        train_en = 1'b1;
        push(8'h00);
        lvl = 1'b0;
        pulses = 0;
        for (int k = 0; k < 152; k++) begin
            b = ref_pat[7 - (k % 8)];
            if (b == lvl) w = {8{b}};
            else          w = b ? 8'hF8 : 8'h07;
            push(w);
            lvl = b;
            pulses += phase_up + phase_dn;
            if (k == 7)   chk("R8 first candidate rejected", sample_sel, 1);
            if (k == 23)  chk("R8 third candidate rejected", sample_sel, 3);
            if (k == 150) chk("R9 not locked before 16th byte", locked, 0);
        end
        chk("R9 locked after 16 bytes", locked, 1);
        chk("R9 chosen sample", sample_sel, 3);
        chk("R7 no pulses while hunting", pulses, 0);

        // tracking table
        both = 0;
        for (int i = 0; i < NV; i++) begin
            push(TV[i][9:2]);
            chk($sformatf("R4 up vec %0d", i), phase_up, TV[i][1]);
            chk($sformatf("R4 dn vec %0d", i), phase_dn, TV[i][0]);
            chk($sformatf("R10 rec_bit vec %0d", i), rec_bit, TV[i][5]);
            both += (phase_up && phase_dn) ? 1 : 0;
        end
        chk("R6 exclusive pulses", both, 0);

        // R9 lock persists with train_en dropped, selection frozen
        train_en = 1'b0;
        push(8'hFF);
        push(8'h00);
        chk("R9 lock sticky", locked, 1);
        chk("R9 sel frozen", sample_sel, 3);
        chk("R10 rec_bit low", rec_bit, 0);

        // R1 reset again returns to idle
        rst_n = 1'b0;
        #1;
        chk("R1 locked cleared", locked, 0);
        chk("R1 sel cleared", sample_sel, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule